// File: doc/BRIEF.md
# Five-Level Stacked-Carrier PWM Gate Generator

This block drives the eight power switches of a single-phase inverter built from two full-bridge cells in series. The summed cell outputs give five voltage steps: minus two, minus one, zero, plus one and plus two times one cell's DC supply. A signed modulating word is compared against four triangular carriers. The carriers have equal amplitude and equal frequency and are stacked in adjacent bands. How many carriers the word lies above picks the output step. That step is turned into a switch pattern for each of the four half-bridge legs, and each leg is given complementary gates with a dead-time gap.

All four carriers come from one up/down counter whose ramp length is set at a port in clock ticks. Each band is that counter shifted by a multiple of the ramp length. The modulating word is captured only at the top of each carrier ramp, so it cannot add switching edges partway through a period. Gates stay off from reset until the first capture.

Top module: `pwm5_gen`

## Requirements
- R1: During reset and afterwards, until a modulating word has been captured at a carrier peak, all eight gate outputs are 0.
- R2: The carrier counter runs 0, 1, …, H, H-1, …, 1 and then repeats, for a period of 2H clocks, where H is `ramp_len` (values below 2 are treated as 2).
- R3: Band k (k = 0..3) has carrier value (k-2)·H + count. The output step is (number of bands whose carrier is strictly below the captured word) − 2, so it ranges from −2 to +2.
- R4: The modulating input is captured only on the clock at which the counter is at its peak. A change to the input that comes and goes between two peaks has no effect on the gates.
- R5: Leg i drives `gate[2i]` (upper switch) and `gate[2i+1]` (lower switch). Legs 0 and 1 are the left and right legs of cell one, and legs 2 and 3 are those of cell two. The steady gate words are: step +2 = 8'h99, +1 = 8'h59, 0 = 8'h55, −1 = 8'h56, −2 = 8'h66. Each zero-output cell turns on both of its upper switches.
- R6: The two gates of a leg are never on at the same time.
- R7: When a leg's wanted state flips, both of its gates are off for DEAD_CYC+1 clocks before the new switch turns on. DEAD_CYC is at least 2.
- R8: A captured word above 2H, or at or below −2H, holds step +2 or step −2 with no switching at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_in | input | MOD_W | Signed modulating word, in carrier ticks |
| ramp_len | input | CNT_W | Carrier ramp length H in clocks (half period) |
| gate | output | 8 | Switch gate lines, two per leg |

## Verification
Each fault shows up at the ports within one carrier period. A wrong counter turn-around or a wrong band offset changes how many clocks per period each gate word is held. A broken capture lets a short input pulse reach the gates at once. A dead-time counter that is off by one moves both the gap count and the on-time of each step by exactly one clock. A wrong step-to-leg map gives a gate word outside the five allowed ones, or a leg with both gates on.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;

    localparam int NUM_BANDS = 4;
    localparam int NUM_LEGS  = 4;

    typedef logic signed [2:0] level_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_gate_t;

    // wanted upper-switch state of {right, left} leg of one cell
    function automatic logic [1:0] cell_legs(input logic signed [1:0] v);
        case (v)
            2'sd1:   return 2'b01;
            -2'sd1:  return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    // wanted upper-switch state of all legs: {cell2 R, cell2 L, cell1 R, cell1 L}
    function automatic logic [3:0] level_to_legs(input level_t l);
        case (l)
            3'sd2:   return {cell_legs(2'sd1),  cell_legs(2'sd1)};
            3'sd1:   return {cell_legs(2'sd0),  cell_legs(2'sd1)};
            -3'sd1:  return {cell_legs(2'sd0),  cell_legs(-2'sd1)};
            -3'sd2:  return {cell_legs(-2'sd1), cell_legs(-2'sd1)};
            default: return {cell_legs(2'sd0),  cell_legs(2'sd0)};
        endcase
    endfunction

endpackage

// File: rtl/pwm5_carrier.sv
module pwm5_carrier #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] ramp_len,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] span,
    output logic             at_peak
);
    localparam logic [CNT_W-1:0] MIN_SPAN = CNT_W'(2);

    logic [CNT_W-1:0] cnt_q;
    logic             up_q;

    assign span    = (ramp_len < MIN_SPAN) ? MIN_SPAN : ramp_len;
    assign at_peak = up_q && (cnt_q >= span);
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (up_q) begin
            if (at_peak) begin
                cnt_q <= cnt_q - 1'b1;
                up_q  <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) up_q <= 1'b1;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q) - 1'b1)) // R2
        else $error("carrier counter jumped");

endmodule

// File: rtl/pwm5_level.sv
module pwm5_level
    import pwm5_pkg::*;
#(
    parameter int MOD_W = 12,
    parameter int CNT_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [MOD_W-1:0] mod_in,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [CNT_W-1:0]        span,
    input  logic                    at_peak,
    output level_t                  level,
    output logic                    en
);
    localparam int SW = ((MOD_W > CNT_W + 3) ? MOD_W : CNT_W + 3) + 1;

    logic signed [MOD_W-1:0] mod_q;
    logic                    seen_q;
    logic                    en_q;
    level_t                  level_q;
    logic signed [SW-1:0]    mod_ext;
    logic [NUM_BANDS-1:0]    above;
    logic [3:0]              n_above;

    assign mod_ext = SW'(mod_q);

    for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
        localparam logic signed [SW-1:0] OFS = SW'(k) - SW'(2);
        logic signed [SW-1:0] car;
        assign car      = OFS * $signed(SW'(span)) + $signed(SW'(cnt));
        assign above[k] = mod_ext > car;
    end

    always_comb begin
        n_above = '0;
        for (int k = 0; k < NUM_BANDS; k++) n_above = n_above + 4'(above[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_q   <= '0;
            seen_q  <= 1'b0;
            en_q    <= 1'b0;
            level_q <= '0;
        end else begin
            if (at_peak) begin
                mod_q  <= mod_in;
                seen_q <= 1'b1;
            end
            en_q    <= seen_q;
            level_q <= level_t'($signed(n_above) - 4'sd2);
        end
    end

    assign level = level_q;
    assign en    = en_q;

    AST_SAMPLE_AT_PEAK: assert property (@(posedge clk) disable iff (rst)
        !$stable(mod_q) |-> $past(at_peak)) // R4
        else $error("modulating word captured off-peak");

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        en_q |-> (level_q >= -3'sd2 && level_q <= 3'sd2)) // R3
        else $error("level out of range");

endmodule

// File: rtl/pwm5_leg.sv
module pwm5_leg
    import pwm5_pkg::*;
#(
    parameter int DEAD_CYC = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      want_hi,
    output leg_gate_t g
);
    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DT = DW'(DEAD_CYC);

    logic          tgt_q;
    logic [DW-1:0] wait_q;
    leg_gate_t     g_q;

    initial begin
        if (DEAD_CYC < 2) $error("DEAD_CYC must be at least 2");
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= 1'b0;
            wait_q <= DT;
            g_q    <= '0;
        end else if (!en || (want_hi != tgt_q)) begin
            tgt_q  <= want_hi;
            wait_q <= DT;
            g_q    <= '0;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
            g_q    <= '0;
        end else begin
            g_q.hi <= tgt_q;
            g_q.lo <= !tgt_q;
        end
    end

    assign g = g_q;

    AST_LEG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(g_q.hi && g_q.lo)) // R6
        else $error("leg shoot-through");

    AST_DEAD_HI: assert property (@(posedge clk) disable iff (rst)
        $rose(g_q.hi) |-> ($past(!g_q.lo, 1) && $past(!g_q.lo, 2))) // R7
        else $error("upper switch on without dead time");

    AST_DEAD_LO: assert property (@(posedge clk) disable iff (rst)
        $rose(g_q.lo) |-> ($past(!g_q.hi, 1) && $past(!g_q.hi, 2))) // R7
        else $error("lower switch on without dead time");

endmodule

// File: rtl/pwm5_gen.sv
module pwm5_gen
    import pwm5_pkg::*;
#(
    parameter int MOD_W    = 12,
    parameter int CNT_W    = 10,
    parameter int DEAD_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [MOD_W-1:0] mod_in,
    input  logic [CNT_W-1:0]        ramp_len,
    output logic [2*NUM_LEGS-1:0]   gate
);
    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    span;
    logic                at_peak;
    level_t              level;
    logic                en;
    logic [NUM_LEGS-1:0] want;

    pwm5_carrier #(.CNT_W(CNT_W)) u_car (
        .clk(clk), .rst(rst), .ramp_len(ramp_len),
        .cnt(cnt), .span(span), .at_peak(at_peak)
    );

    pwm5_level #(.MOD_W(MOD_W), .CNT_W(CNT_W)) u_lvl (
        .clk(clk), .rst(rst), .mod_in(mod_in), .cnt(cnt), .span(span),
        .at_peak(at_peak), .level(level), .en(en)
    );

    assign want = level_to_legs(level);

    for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
        leg_gate_t lg;
        pwm5_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk(clk), .rst(rst), .en(en), .want_hi(want[i]), .g(lg)
        );
        assign gate[2*i]   = lg.hi;
        assign gate[2*i+1] = lg.lo;
    end

    AST_OFF_BEFORE_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        !en |-> (gate == '0)) // R1
        else $error("gates active before first capture");

endmodule

// File: tb/sim_pwm5_gen.sv
module sim_pwm5_gen;
    localparam int MOD_W = 12;
    localparam int CNT_W = 10;
    localparam int DT    = 2;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic signed [MOD_W-1:0] mod_drv = '0;
    logic [CNT_W-1:0]        ramp = CNT_W'(8);
    logic [7:0]              gate;

    int n_tests = 0;
    int n_fail  = 0;
    int ecnt    = 0;
    int overlap = 0;
    bit done    = 1'b0;

    logic [7:0] pat [5];

    pwm5_gen #(.MOD_W(MOD_W), .CNT_W(CNT_W), .DEAD_CYC(DT)) u0 (
        .clk(clk), .rst(rst), .mod_in(mod_drv), .ramp_len(ramp), .gate(gate)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ecnt <= 0;
        else     ecnt <= ecnt + 1;
    end

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++)
            if (gate[2*i] && gate[2*i+1]) overlap++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int h);
        @(negedge clk);
        rst     = 1'b1;
        ramp    = CNT_W'(h);
        mod_drv = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic count_pat(input int n, input logic [7:0] p, output int hits);
        hits = 0;
        repeat (n) begin
            @(negedge clk);
            if (gate == p) hits++;
        end
    endtask

    initial begin
        int nz, hits, h_cnt, l_cnt, ok, h;
        int hlist [2];
        pat[0] = 8'h66; pat[1] = 8'h56; pat[2] = 8'h55; pat[3] = 8'h59; pat[4] = 8'h99;
        hlist[0] = 8; hlist[1] = 6;

        // R1: reset state and silence until first capture
        @(negedge clk);
        check("R1 gates in reset", int'(gate), 0);
        do_reset(8);
        nz = 0;
        repeat (8) begin
            @(negedge clk);
            if (gate != 8'h00) nz++;
        end
        check("R1 gates before first capture", nz, 0);

        // R8 / R5: saturated words give constant extreme steps
        mod_drv = 12'sd17;
        repeat (48) @(negedge clk);
        count_pat(16, 8'h99, hits);
        check("R8 R5 step +2 held", hits, 16);
        mod_drv = -12'sd19;
        repeat (48) @(negedge clk);
        count_pat(16, 8'h66, hits);
        check("R8 R5 step -2 held", hits, 16);
        mod_drv = -12'sd16;
        repeat (48) @(negedge clk);
        count_pat(16, 8'h66, hits);
        check("R8 word at -2H holds -2", hits, 16);

        // R4: pulse between peaks has no effect
        while ((ecnt % 16) != 0) @(negedge clk);
        mod_drv = 12'sd17;
        ok = 0;
        repeat (6) begin
            @(negedge clk);
            if (gate == 8'h66) ok++;
        end
        mod_drv = -12'sd19;
        repeat (20) begin
            @(negedge clk);
            if (gate == 8'h66) ok++;
        end
        check("R4 off-peak pulse ignored", ok, 26);

        // R2 R3 R5 R7: duty sweep across every band and two ramp lengths
        foreach (hlist[hi]) begin
            h = hlist[hi];
            do_reset(h);
            for (int k = 0; k < 4; k++) begin
                for (int r = 3; r <= ((h == 8) ? 5 : 4); r++) begin
                    mod_drv = MOD_W'((k - 2) * h + r);
                    repeat (6 * h) @(negedge clk);
                    h_cnt = 0;
                    l_cnt = 0;
                    repeat (2 * h) begin
                        @(negedge clk);
                        if (gate == pat[k+1]) h_cnt++;
                        if (gate == pat[k])   l_cnt++;
                    end
                    check($sformatf("R3 R2 R5 H=%0d band %0d r=%0d upper-step clocks", h, k, r),
                          h_cnt, 2 * r - 1 - (DT + 1));
                    check($sformatf("R3 R2 R5 H=%0d band %0d r=%0d lower-step clocks", h, k, r),
                          l_cnt, 2 * h - (2 * r - 1) - (DT + 1));
                    check($sformatf("R7 H=%0d band %0d r=%0d dead clocks", h, k, r),
                          2 * h - h_cnt - l_cnt, 2 * (DT + 1));
                end
            end
        end

        // R6: no leg ever had both gates on
        check("R6 leg overlap cycles", overlap, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule